// File: doc/BRIEF.md
# Three-Phase Scan Sequencer

This block drives a bootstrapped shift chain built only from n-type devices. Such a chain selects the sensors of an array one at a time. Each shift step needs three control phases that never overlap. Within a stage, the first phase precharges the bootstrap node, the second drives the pass device and the third resets it. A global reset line clears the chain before a token is walked through it. The sequencer produces the three phases and the reset. It also keeps its own copy of which sensor the chain currently selects, and issues a one-cycle readout strobe on every phase edge that belongs to a selected sensor.

The phases can come from one of two sources. In internal mode the block times them with counters: each phase lasts a fixed number of cycles, and a programmable number of all-low gap cycles separates consecutive phases. In external mode the phases arrive from a self-timed oscillator path. The block synchronises them, blanks any overlap and mirrors them, and the same step tracking is applied. A run begins on a start command. It either stops after the last sensor and flags done, or, in continuous mode, re-enters the reset period and begins again at sensor 0.

Top module: `scan_phase_seq`

## Requirements
- R1: While reset is asserted and afterwards until the first start, scan_o is 3'b000, grst_o, sel_o, done_o and strobe_o are low, and idx_o is 0.
- R2: In internal mode, scan_o[0], scan_o[1] and scan_o[2] rise in that repeating order. Each stays high for exactly PH_LEN cycles, and at most one bit of scan_o is high in any cycle.
- R3: In internal mode, exactly gap_i cycles with scan_o all low separate the end of one phase from the start of the next, including across step boundaries. With gap_i = 0 the phases are back to back.
- R4: After start, grst_o is high for one complete phase sequence, 3*PH_LEN + 2*gap_i cycles in internal mode, with sel_o low. grst_o falls when phase 3 ends, and at that point sel_o rises with idx_o = 0.
- R5: Each later end of phase 3 advances idx_o by one while sel_o stays high, covering 0 through last_i. Here last_i is the sensor count minus one.
- R6: With cont_i low, the end of phase 3 for sensor last_i stops all phases and raises done_o with sel_o low. The run then takes 3*(last_i+1)*(PH_LEN+gap_i) + 3*PH_LEN + 2*gap_i cycles after the start edge. done_o stays high until the next start.
- R7: With cont_i high, the end of the step for sensor last_i leads into a new grst_o period of one full phase sequence. Selection then resumes at idx_o = 0, and no done is raised.
- R8: strobe_o[p] is a one-cycle pulse in the first cycle that scan_o[p] is high, issued only while sel_o is high. Each selected sensor therefore produces one strobe per phase, and no strobe appears during a grst_o period.
- R9: A start command while a run is in progress has no effect on the sequence or on its total length.
- R10: In external mode (ext_mode_i = 1), scan_o reproduces ext_ph_i after a two-flop synchroniser, two clock edges later. A step ends when the synchronised phase 3 falls, and grst_o, idx_o, sel_o and done_o follow R4 to R6.
- R11: In external mode, in any cycle where more than one synchronised external phase is high, scan_o is driven to 3'b000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command, sampled on the clock edge |
| ext_mode_i | input | 1 | 1 = phases from ext_ph_i, 0 = internally timed phases |
| cont_i | input | 1 | 1 = wrap to a new reset period after the last sensor |
| last_i | input | IDX_W | Index of the last sensor (count minus one) |
| gap_i | input | GAP_W | All-low cycles between consecutive internal phases |
| ext_ph_i | input | 3 | Phases from the self-timed path, asynchronous |
| scan_o | output | 3 | Phase outputs 1, 2, 3 (bit 0 = precharge, bit 1 = drive, bit 2 = reset) |
| grst_o | output | 1 | Global chain reset |
| idx_o | output | IDX_W | Index of the currently selected sensor |
| sel_o | output | 1 | A sensor is currently selected |
| strobe_o | output | 3 | Readout pulse on the rise of each phase |
| done_o | output | 1 | Non-continuous run finished |

## Verification
The hardest state to reach from the ports is external mode with overlapping phases. The external inputs go through a synchroniser, and the phase vector that would be driven is never visible directly. The bench holds two external phases high together for longer than the synchroniser latency, then samples scan_o two edges later to confirm the blanking. The continuous wrap is also hard to see, because it is visible only as a second reset period and a return of idx_o to 0. The bench leaves a continuous run going for several passes and follows the strobe-tagged index sequence through each wrap. It then clears cont_i in mid-run and confirms that the run stops cleanly.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  localparam int NPH = 3;

  typedef logic [NPH-1:0] phase_vec_t;

  // One-hot phase vector for phase slot s (0, 1 or 2)
  function automatic phase_vec_t ph_decode(input logic [1:0] s);
    phase_vec_t v;
    v = '0;
    unique case (s)
      2'd0:    v = 3'b001;
      2'd1:    v = 3'b010;
      default: v = 3'b100;
    endcase
    return v;
  endfunction

  // Next phase slot in the precharge -> drive -> reset rotation
  function automatic logic [1:0] ph_next(input logic [1:0] s);
    return (s == 2'd2) ? 2'd0 : s + 2'd1;
  endfunction

  // True when more than one phase bit is set
  function automatic logic multi_hot(input phase_vec_t v);
    return (v & (v - phase_vec_t'(1))) != '0;
  endfunction

endpackage

// File: rtl/scan_phase_gen.sv
module scan_phase_gen
  import scan_seq_pkg::*;
#(
  parameter int PH_LEN = 2,
  parameter int GAP_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ext_mode_i,
  input  logic             halt_i,
  input  logic [GAP_W-1:0] gap_i,
  output phase_vec_t       ph_o,
  output logic             step_end_o
);

  localparam int PH_W  = (PH_LEN > 1) ? $clog2(PH_LEN) : 1;
  localparam int TMR_W = (PH_W > GAP_W) ? PH_W : GAP_W;
  localparam logic [TMR_W-1:0] PH_LD = TMR_W'(PH_LEN - 1);

  logic             act_q, act_d;
  logic             gap_q, gap_d;
  logic [1:0]       sel_q, sel_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  phase_vec_t       ph_q, ph_d;
  logic [1:0]       nsel;
  logic [TMR_W-1:0] gap_ld;
  logic             tmr_zero;

  assign nsel       = ph_next(sel_q);
  assign gap_ld     = TMR_W'(gap_i) - TMR_W'(1);
  assign tmr_zero   = (tmr_q == '0);
  assign step_end_o = act_q & ~gap_q & ~ext_mode_i & tmr_zero & (sel_q == 2'd2);
  assign ph_o       = ph_q;

  always_comb begin
    act_d = act_q;
    gap_d = gap_q;
    sel_d = sel_q;
    tmr_d = tmr_q;
    ph_d  = ph_q;
    if (start_i && !ext_mode_i) begin
      act_d = 1'b1;
      gap_d = 1'b0;
      sel_d = 2'd0;
      tmr_d = PH_LD;
      ph_d  = ph_decode(2'd0);
    end else if (act_q) begin
      if (ext_mode_i) begin
        act_d = 1'b0;
        gap_d = 1'b0;
        ph_d  = '0;
      end else if (!gap_q) begin
        if (!tmr_zero) begin
          tmr_d = tmr_q - TMR_W'(1);
        end else if (step_end_o && halt_i) begin
          act_d = 1'b0;
          ph_d  = '0;
        end else if (gap_i == '0) begin
          sel_d = nsel;
          tmr_d = PH_LD;
          ph_d  = ph_decode(nsel);
        end else begin
          gap_d = 1'b1;
          sel_d = nsel;
          tmr_d = gap_ld;
          ph_d  = '0;
        end
      end else begin
        if (!tmr_zero) begin
          tmr_d = tmr_q - TMR_W'(1);
        end else begin
          gap_d = 1'b0;
          tmr_d = PH_LD;
          ph_d  = ph_decode(sel_q);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      gap_q <= 1'b0;
      sel_q <= 2'd0;
      tmr_q <= '0;
      ph_q  <= '0;
    end else begin
      act_q <= act_d;
      gap_q <= gap_d;
      sel_q <= sel_d;
      tmr_q <= tmr_d;
      ph_q  <= ph_d;
    end
  end

endmodule

// File: rtl/scan_ext_sync.sv
module scan_ext_sync
  import scan_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  phase_vec_t ext_ph_i,
  output phase_vec_t ph_o
);

  phase_vec_t stg_q [SYNC_STAGES];

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= '0;
          else        stg_q[g] <= ext_ph_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= '0;
          else        stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  // Overlapping external phases are never passed on
  assign ph_o = multi_hot(stg_q[SYNC_STAGES-1]) ? '0 : stg_q[SYNC_STAGES-1];

endmodule

// File: rtl/scan_step_track.sv
module scan_step_track #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             step_end_i,
  input  logic [IDX_W-1:0] last_i,
  input  logic             cont_i,
  output logic             start_go_o,
  output logic             halt_o,
  output logic             grst_o,
  output logic             sel_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);

  logic             run_q, run_d;
  logic             grst_q, grst_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;
  logic             at_last;
  logic             adv;

  assign start_go_o = start_i & ~run_q;
  assign at_last    = (idx_q == last_i);
  assign adv        = run_q & step_end_i;
  assign halt_o     = adv & ~grst_q & at_last & ~cont_i;

  always_comb begin
    run_d  = run_q;
    grst_d = grst_q;
    idx_d  = idx_q;
    done_d = done_q;
    if (start_go_o) begin
      run_d  = 1'b1;
      grst_d = 1'b1;
      idx_d  = '0;
      done_d = 1'b0;
    end else if (adv) begin
      if (grst_q) begin
        grst_d = 1'b0;
        idx_d  = '0;
      end else if (at_last) begin
        idx_d = '0;
        if (cont_i) begin
          grst_d = 1'b1;
        end else begin
          run_d  = 1'b0;
          done_d = 1'b1;
        end
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      grst_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      grst_q <= grst_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  assign grst_o = grst_q;
  assign sel_o  = run_q & ~grst_q;
  assign idx_o  = idx_q;
  assign done_o = done_q;

endmodule

// File: rtl/scan_phase_seq.sv
module scan_phase_seq
  import scan_seq_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int GAP_W  = 3,
  parameter int PH_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ext_mode_i,
  input  logic             cont_i,
  input  logic [IDX_W-1:0] last_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic [2:0]       ext_ph_i,
  output logic [2:0]       scan_o,
  output logic             grst_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             sel_o,
  output logic [2:0]       strobe_o,
  output logic             done_o
);

  phase_vec_t gen_ph;
  phase_vec_t ext_ph;
  phase_vec_t ph_eff;
  phase_vec_t scan_q;
  logic       gen_end;
  logic       ext_end;
  logic       step_end;
  logic       start_go;
  logic       halt;

  scan_phase_gen #(.PH_LEN(PH_LEN), .GAP_W(GAP_W)) u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_go),
    .ext_mode_i (ext_mode_i),
    .halt_i     (halt),
    .gap_i      (gap_i),
    .ph_o       (gen_ph),
    .step_end_o (gen_end)
  );

  scan_ext_sync #(.SYNC_STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_ph_i (ext_ph_i),
    .ph_o     (ext_ph)
  );

  assign ph_eff   = ext_mode_i ? ext_ph : gen_ph;
  assign ext_end  = ext_mode_i & scan_q[2] & ~ph_eff[2];
  assign step_end = ext_mode_i ? ext_end : gen_end;

  scan_step_track #(.IDX_W(IDX_W)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .step_end_i (step_end),
    .last_i     (last_i),
    .cont_i     (cont_i),
    .start_go_o (start_go),
    .halt_o     (halt),
    .grst_o     (grst_o),
    .sel_o      (sel_o),
    .idx_o      (idx_o),
    .done_o     (done_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scan_q <= '0;
    else        scan_q <= ph_eff;
  end

  assign scan_o   = ph_eff;
  assign strobe_o = ph_eff & ~scan_q & {NPH{sel_o}};

endmodule

// File: rtl/scan_phase_seq_chk.sv
module scan_phase_seq_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_mode_i,
  input logic [IDX_W-1:0] last_i,
  input logic [2:0]       scan_o,
  input logic             grst_o,
  input logic [IDX_W-1:0] idx_o,
  input logic             sel_o,
  input logic [2:0]       strobe_o,
  input logic             done_o
);

  // R2
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(scan_o) <= 1);

  // R8
  strobe_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o != 3'b000) |-> (sel_o && !grst_o));

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o != 3'b000) |=> ((strobe_o & $past(strobe_o)) == 3'b000));

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_o |-> (idx_o <= last_i));

  // R4
  grst_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(grst_o) && !done_o) |-> (sel_o && idx_o == '0));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !ext_mode_i) |-> (scan_o == 3'b000 && !sel_o && !grst_o));

endmodule

bind scan_phase_seq scan_phase_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ext_mode_i (ext_mode_i),
  .last_i     (last_i),
  .scan_o     (scan_o),
  .grst_o     (grst_o),
  .idx_o      (idx_o),
  .sel_o      (sel_o),
  .strobe_o   (strobe_o),
  .done_o     (done_o)
);

// File: tb/scan_phase_seq_test.sv
module scan_phase_seq_test;

  localparam int IDX_W  = 4;
  localparam int GAP_W  = 3;
  localparam int PH_LEN = 2;

  // {last, gap, expected run length}: length = 3*(last+1)*(PH_LEN+gap) + 3*PH_LEN + 2*gap
  localparam logic [23:0] VEC [4] = '{
    {8'd0, 8'd0, 8'd12},
    {8'd2, 8'd1, 8'd35},
    {8'd4, 8'd3, 8'd87},
    {8'd7, 8'd0, 8'd54}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i;
  logic             ext_mode_i;
  logic             cont_i;
  logic [IDX_W-1:0] last_i;
  logic [GAP_W-1:0] gap_i;
  logic [2:0]       ext_ph_i;
  logic [2:0]       scan_o;
  logic             grst_o;
  logic [IDX_W-1:0] idx_o;
  logic             sel_o;
  logic [2:0]       strobe_o;
  logic             done_o;

  int n_chk = 0;
  int n_err = 0;

  // monitor state
  bit   m_en = 0;
  int   m_hi [3];
  int   m_stb [3];
  int   m_grst, m_grst_rise, m_err, exp_idx, exp_n, last_p;
  logic [2:0] prev_scan;
  logic       prev_grst;

  always #2 clk = ~clk;

  scan_phase_seq #(.IDX_W(IDX_W), .GAP_W(GAP_W), .PH_LEN(PH_LEN)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ext_mode_i(ext_mode_i),
    .cont_i(cont_i), .last_i(last_i), .gap_i(gap_i), .ext_ph_i(ext_ph_i),
    .scan_o(scan_o), .grst_o(grst_o), .idx_o(idx_o), .sel_o(sel_o),
    .strobe_o(strobe_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mon_clear(input int n);
    for (int p = 0; p < 3; p++) begin m_hi[p] = 0; m_stb[p] = 0; end
    m_grst = 0; m_grst_rise = 0; m_err = 0; exp_idx = 0; exp_n = n; last_p = 2;
    prev_scan = 3'b000; prev_grst = 1'b0;
  endtask

  always @(negedge clk) begin
    if (m_en) begin
      if ($countones(scan_o) > 1) m_err++;
      for (int p = 0; p < 3; p++) begin
        if (scan_o[p]) m_hi[p]++;
        if (scan_o[p] && !prev_scan[p]) begin
          if (p != (last_p + 1) % 3) m_err++;
          last_p = p;
        end
        if (strobe_o[p]) begin
          m_stb[p]++;
          if (grst_o || !sel_o) m_err++;
        end
      end
      if (strobe_o[0]) begin
        if (int'(idx_o) != exp_idx) m_err++;
        exp_idx = (exp_idx + 1) % exp_n;
      end
      if (grst_o) m_grst++;
      if (grst_o && !prev_grst) m_grst_rise++;
      prev_scan = scan_o;
      prev_grst = grst_o;
    end
  end

  task automatic run_int(input int last, input int gap, input int exp_t, input int repulse, input string tag);
    int cyc;
    int n;
    n = last + 1;
    ext_mode_i = 1'b0; cont_i = 1'b0;
    last_i = IDX_W'(last); gap_i = GAP_W'(gap);
    mon_clear(n);
    @(negedge clk); start_i = 1'b1; m_en = 1;
    @(negedge clk); start_i = 1'b0;
    chk(done_o == 1'b0 && grst_o == 1'b1 && sel_o == 1'b0, {tag, " R4 R6 start state"},
        {done_o, grst_o, sel_o}, 3'b010);
    cyc = 0;
    while (!done_o && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      start_i = (cyc == repulse);
    end
    start_i = 1'b0;
    m_en = 0;
    chk(cyc == exp_t, {tag, " R6 run length"}, cyc, exp_t);
    chk(m_grst == 3 * PH_LEN + 2 * gap, {tag, " R4 grst cycles"}, m_grst, 3 * PH_LEN + 2 * gap);
    chk(m_hi[0] == PH_LEN * (n + 1) && m_hi[1] == PH_LEN * (n + 1) && m_hi[2] == PH_LEN * (n + 1),
        {tag, " R2 R3 phase widths"}, m_hi[2], PH_LEN * (n + 1));
    chk(m_stb[0] == n && m_stb[1] == n && m_stb[2] == n, {tag, " R8 strobe count"}, m_stb[1], n);
    chk(m_err == 0, {tag, " R2 R5 R8 order/index/overlap"}, m_err, 0);
    chk(scan_o == 3'b000 && sel_o == 1'b0 && grst_o == 1'b0, {tag, " R6 idle after done"},
        {scan_o, sel_o, grst_o}, 0);
  endtask

  task automatic ext_phase(input int p);
    @(negedge clk); ext_ph_i = 3'b001 << p;
    repeat (4) @(negedge clk);
    ext_ph_i = 3'b000;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int cyc;
    rst_n = 1'b0; start_i = 1'b0; ext_mode_i = 1'b0; cont_i = 1'b0;
    last_i = '0; gap_i = '0; ext_ph_i = 3'b000;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(scan_o == 3'b000 && grst_o == 1'b0 && sel_o == 1'b0 && done_o == 1'b0 &&
        strobe_o == 3'b000 && idx_o == '0, "R1 in reset", {scan_o, grst_o, sel_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(scan_o == 3'b000 && grst_o == 1'b0 && sel_o == 1'b0 && done_o == 1'b0 && idx_o == '0,
        "R1 after release", {scan_o, grst_o, sel_o, done_o}, 0);

    // table of internal-mode vectors
    for (int v = 0; v < 4; v++) begin
      run_int(int'(VEC[v][23:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]), -1, $sformatf("vec%0d R2 R3 R5", v));
      repeat (3) @(negedge clk);
    end

    // R9: second start in mid-run must not change the length
    run_int(2, 1, 35, 10, "R9 restart ignored");

    // R7: continuous mode wraps through a new grst period to index 0
    ext_mode_i = 1'b0; last_i = 4'd1; gap_i = 3'd0; cont_i = 1'b1;
    mon_clear(2);
    @(negedge clk); start_i = 1'b1; m_en = 1;
    @(negedge clk); start_i = 1'b0;
    repeat (100) @(negedge clk);
    chk(done_o == 1'b0, "R7 no done while continuous", done_o, 0);
    chk(m_grst_rise >= 4, "R7 grst repeated per pass", m_grst_rise, 4);
    chk(m_stb[0] >= 8, "R7 sensors keep cycling", m_stb[0], 8);
    cont_i = 1'b0;
    cyc = 0;
    while (!done_o && cyc < 60) begin @(negedge clk); cyc++; end
    m_en = 0;
    chk(done_o == 1'b1, "R7 R6 stops once cont cleared", done_o, 1);
    chk(m_err == 0, "R7 R5 wrapped index order", m_err, 0);
    repeat (3) @(negedge clk);

    // R11: overlapping external phases are blanked
    ext_mode_i = 1'b1; last_i = 4'd1;
    @(negedge clk); ext_ph_i = 3'b011;
    repeat (3) @(negedge clk);
    chk(scan_o == 3'b000, "R11 overlap blanked", scan_o, 0);
    ext_ph_i = 3'b000;
    repeat (3) @(negedge clk);

    // R10: external phases, two-edge latency and step tracking
    mon_clear(2);
    @(negedge clk); start_i = 1'b1; m_en = 1;
    @(negedge clk); start_i = 1'b0;
    chk(grst_o == 1'b1 && sel_o == 1'b0, "R10 R4 grst on start", grst_o, 1);
    ext_ph_i = 3'b001;
    @(negedge clk);
    chk(scan_o == 3'b000, "R10 one edge not yet through", scan_o, 0);
    @(negedge clk);
    chk(scan_o == 3'b001, "R10 two edges through", scan_o, 1);
    repeat (2) @(negedge clk);
    ext_ph_i = 3'b000;
    repeat (4) @(negedge clk);
    ext_phase(1);
    ext_phase(2);
    chk(grst_o == 1'b0 && sel_o == 1'b1 && idx_o == '0, "R10 R4 grst ends on phase 3 fall",
        {grst_o, sel_o, idx_o}, 6'b010000);
    for (int p = 0; p < 3; p++) ext_phase(p);
    chk(idx_o == 4'd1 && sel_o == 1'b1, "R10 R5 index advances", idx_o, 1);
    for (int p = 0; p < 3; p++) ext_phase(p);
    m_en = 0;
    chk(done_o == 1'b1 && sel_o == 1'b0, "R10 R6 done after last", done_o, 1);
    chk(m_stb[0] == 2 && m_stb[1] == 2 && m_stb[2] == 2, "R10 R8 strobes per sensor", m_stb[2], 2);
    chk(m_err == 0, "R10 R8 order/index", m_err, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule